// File: doc/BRIEF.md
# Two-Dimensional Parity Product Codec

This block protects a 64-bit word that crosses an unreliable vertical link between stacked dies. The word is treated as an 8×8 grid. The encoder appends one parity bit per row, one parity bit per column and a single corner bit, which gives an 81-bit codeword. The decoder sits on the far side of the link. It recomputes the row, column and corner parities of the received word and compares them with the received check bits. A single flipped bit anywhere in the codeword is repaired. Wider damage is reported as uncorrectable.

The search for a flipped data bit is a plain intersection. Exactly one failing row and exactly one failing column, together with a failing corner, point at the one grid cell to invert. A single failing check bit is recognised from its own syndrome pattern. In that case the data is forwarded untouched and the repair flag is still raised. Every two-bit fault is reported as uncorrectable and is never silently miscorrected.

Both halves are a few XOR levels deep. A parameter can place one register stage on all outputs, so that the codec can be placed between pipeline flops.

Top module: `grid_parity_codec`

## Requirements
- R1: Bits [63:0] of the encoder codeword equal the input data. Data bit index r*8+c sits in row r, column c. Bit 64+r is the XOR of the eight data bits of row r.
- R2: Bit 72+c of the encoder codeword is the XOR of data bits c, c+8, …, c+56. Bit 80 is the XOR of all 64 data bits, so the whole codeword always has even parity.
- R3: A received codeword with no fault gives data equal to its bits [63:0], with both flags low.
- R4: A received codeword with exactly one flipped data bit gives the original data, with the fixed flag high and the fatal flag low.
- R5: A received codeword with exactly one flipped check bit (row, column or corner) gives the data bits unchanged, with the fixed flag high and the fatal flag low.
- R6: A received codeword with any two flipped bits raises the fatal flag, keeps the fixed flag low, and gives data equal to the received bits [63:0].
- R7: The fixed and fatal flags are never high together.
- R8: With OUT_REG=1 every output appears one rising clock edge after its input and reset clears all outputs to zero. With OUT_REG=0 the outputs follow the inputs combinationally.
- R9: Any received word with odd overall parity, which covers any odd number of flipped bits, raises at least one of the two flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous active-low reset of the output stage |
| enc_data_i | input | 64 | Data word to encode |
| enc_code_o | output | 81 | Encoded codeword |
| dec_code_i | input | 81 | Codeword received from the link |
| dec_data_o | output | 64 | Corrected, or forwarded, data |
| dec_fixed_o | output | 1 | A single fault was found and repaired |
| dec_fatal_o | output | 1 | An uncorrectable fault was detected |

## Verification
With the output stage enabled, the encoder and decoder results are due one rising edge after their inputs are applied. Without it they are due in the same cycle. The bench drives each stimulus on a falling edge and reads the results on the next falling edge, which is correct for both settings. A dedicated latency scenario samples just after the drive to confirm that the registered outputs still hold the previous result, then samples again just after the rising edge to see the new one.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

   // Decode outcome for one received codeword
   typedef enum logic [1:0] {
      GPC_CLEAN     = 2'd0,
      GPC_FIX_DATA  = 2'd1,
      GPC_FIX_CHECK = 2'd2,
      GPC_FATAL     = 2'd3
   } gpc_class_e;

   function automatic int gpc_code_width(input int rows, input int cols);
      return rows * cols + rows + cols + 1;
   endfunction

endpackage

// File: rtl/gpc_parity_grid.sv
module gpc_parity_grid #(
   parameter int ROWS = 8,
   parameter int COLS = 8,
   localparam int DATA_W = ROWS * COLS
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [ROWS-1:0]   row_par_o,
   output logic [COLS-1:0]   col_par_o,
   output logic              all_par_o
);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_par_o[r] = ^data_i[r*COLS +: COLS];
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic acc;
      always_comb begin
         acc = 1'b0;
         for (int r = 0; r < ROWS; r++) begin
            acc = acc ^ data_i[r*COLS + c];
         end
      end
      assign col_par_o[c] = acc;
   end

   assign all_par_o = ^data_i;

endmodule

// File: rtl/gpc_encoder.sv
module gpc_encoder #(
   parameter int ROWS = 8,
   parameter int COLS = 8,
   localparam int DATA_W = ROWS * COLS,
   localparam int CODE_W = gpc_pkg::gpc_code_width(ROWS, COLS)
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CODE_W-1:0] code_o
);

   logic [ROWS-1:0] row_par;
   logic [COLS-1:0] col_par;
   logic            all_par;

   gpc_parity_grid #(.ROWS(ROWS), .COLS(COLS)) u_grid (
      .data_i    (data_i),
      .row_par_o (row_par),
      .col_par_o (col_par),
      .all_par_o (all_par)
   );

   // Field order, low to high: data, row checks, column checks, corner
   assign code_o = {all_par, col_par, row_par, data_i};

endmodule

// File: rtl/gpc_classify.sv
module gpc_classify
   import gpc_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 8
) (
   input  logic [ROWS-1:0] row_syn_i,
   input  logic [COLS-1:0] col_syn_i,
   input  logic            crn_syn_i,
   output gpc_class_e      class_o
);

   logic row_any, row_multi, row_one;
   logic col_any, col_multi, col_one;

   assign row_any   = |row_syn_i;
   assign row_multi = |(row_syn_i & (row_syn_i - ROWS'(1)));
   assign row_one   = row_any & ~row_multi;

   assign col_any   = |col_syn_i;
   assign col_multi = |(col_syn_i & (col_syn_i - COLS'(1)));
   assign col_one   = col_any & ~col_multi;

   always_comb begin
      if (!row_any && !col_any && !crn_syn_i) begin
         class_o = GPC_CLEAN;
      end else if (row_one && col_one && crn_syn_i) begin
         // one row, one column and the corner disagree: a grid cell flipped
         class_o = GPC_FIX_DATA;
      end else if (((row_one && !col_any) || (col_one && !row_any)) && !crn_syn_i) begin
         // a lone row or column check bit flipped
         class_o = GPC_FIX_CHECK;
      end else if (!row_any && !col_any && crn_syn_i) begin
         // only the corner bit flipped
         class_o = GPC_FIX_CHECK;
      end else begin
         class_o = GPC_FATAL;
      end
   end

endmodule

// File: rtl/gpc_decoder.sv
module gpc_decoder
   import gpc_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 8,
   localparam int DATA_W  = ROWS * COLS,
   localparam int CODE_W  = gpc_pkg::gpc_code_width(ROWS, COLS),
   localparam int ROW_LSB = DATA_W,
   localparam int COL_LSB = DATA_W + ROWS
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] data_o,
   output logic              fixed_o,
   output logic              fatal_o
);

   logic [DATA_W-1:0] rx_data;
   logic [ROWS-1:0]   rx_row, calc_row, row_syn;
   logic [COLS-1:0]   rx_col, calc_col, col_syn;
   logic              rx_crn, calc_all, crn_syn;
   gpc_class_e        cls;
   logic [DATA_W-1:0] flip;

   assign rx_data = code_i[DATA_W-1:0];
   assign rx_row  = code_i[ROW_LSB +: ROWS];
   assign rx_col  = code_i[COL_LSB +: COLS];
   assign rx_crn  = code_i[CODE_W-1];

   gpc_parity_grid #(.ROWS(ROWS), .COLS(COLS)) u_grid (
      .data_i    (rx_data),
      .row_par_o (calc_row),
      .col_par_o (calc_col),
      .all_par_o (calc_all)
   );

   assign row_syn = rx_row ^ calc_row;
   assign col_syn = rx_col ^ calc_col;
   assign crn_syn = rx_crn ^ calc_all;

   gpc_classify #(.ROWS(ROWS), .COLS(COLS)) u_cls (
      .row_syn_i (row_syn),
      .col_syn_i (col_syn),
      .crn_syn_i (crn_syn),
      .class_o   (cls)
   );

   // Intersection of the failing row and failing column selects the cell
   for (genvar r = 0; r < ROWS; r++) begin : g_fr
      for (genvar c = 0; c < COLS; c++) begin : g_fc
         assign flip[r*COLS + c] = (cls == GPC_FIX_DATA) & row_syn[r] & col_syn[c];
      end
   end

   assign data_o  = rx_data ^ flip;
   assign fixed_o = (cls == GPC_FIX_DATA) || (cls == GPC_FIX_CHECK);
   assign fatal_o = (cls == GPC_FATAL);

endmodule

// File: rtl/gpc_stage.sv
module gpc_stage #(
   parameter int W   = 8,
   parameter bit REG = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (REG) begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q <= '0;
         else         q <= d_i;
      end
      assign q_o = q;
   end else begin : g_wire
      assign q_o = d_i;
   end

endmodule

// File: rtl/grid_parity_codec.sv
module grid_parity_codec #(
   parameter int ROWS    = 8,
   parameter int COLS    = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int DATA_W = ROWS * COLS,
   localparam int CODE_W = gpc_pkg::gpc_code_width(ROWS, COLS),
   localparam int BUN_W  = CODE_W + DATA_W + 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] enc_data_i,
   output logic [CODE_W-1:0] enc_code_o,
   input  logic [CODE_W-1:0] dec_code_i,
   output logic [DATA_W-1:0] dec_data_o,
   output logic              dec_fixed_o,
   output logic              dec_fatal_o
);

   if (ROWS != COLS) begin : g_bad_shape
      $error("grid_parity_codec: ROWS and COLS must match");
   end
   if (ROWS < 2) begin : g_bad_size
      $error("grid_parity_codec: grid must be at least 2x2");
   end

   logic [CODE_W-1:0] enc_code;
   logic [DATA_W-1:0] dec_data;
   logic              dec_fixed, dec_fatal;
   logic [BUN_W-1:0]  bun_d, bun_q;

   gpc_encoder #(.ROWS(ROWS), .COLS(COLS)) u_enc (
      .data_i (enc_data_i),
      .code_o (enc_code)
   );

   gpc_decoder #(.ROWS(ROWS), .COLS(COLS)) u_dec (
      .code_i  (dec_code_i),
      .data_o  (dec_data),
      .fixed_o (dec_fixed),
      .fatal_o (dec_fatal)
   );

   assign bun_d = {enc_code, dec_data, dec_fixed, dec_fatal};

   gpc_stage #(.W(BUN_W), .REG(OUT_REG)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (bun_d),
      .q_o    (bun_q)
   );

   assign {enc_code_o, dec_data_o, dec_fixed_o, dec_fatal_o} = bun_q;

endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
   parameter int ROWS    = 8,
   parameter int COLS    = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int DATA_W = ROWS * COLS,
   localparam int CODE_W = gpc_pkg::gpc_code_width(ROWS, COLS)
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [DATA_W-1:0] enc_data_i,
   input logic [CODE_W-1:0] enc_code_o,
   input logic [CODE_W-1:0] dec_code_i,
   input logic [DATA_W-1:0] dec_data_o,
   input logic              dec_fixed_o,
   input logic              dec_fatal_o
);

   logic [DATA_W-1:0] enc_d;
   logic [CODE_W-1:0] code_d;
   logic              seen;

   // Align the inputs with the outputs they produced
   if (OUT_REG) begin : g_delay
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            enc_d  <= '0;
            code_d <= '0;
            seen   <= 1'b0;
         end else begin
            enc_d  <= enc_data_i;
            code_d <= dec_code_i;
            seen   <= 1'b1;
         end
      end
   end else begin : g_direct
      assign enc_d  = enc_data_i;
      assign code_d = dec_code_i;
      assign seen   = 1'b1;
   end

   assert_flags_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dec_fixed_o && dec_fatal_o));

   assert_enc_even_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (^enc_code_o) == 1'b0);

   assert_enc_systematic_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen |-> (enc_code_o[DATA_W-1:0] == enc_d));

   assert_odd_flagged_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && (^code_d)) |-> (dec_fixed_o || dec_fatal_o));

   assert_passthru_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && !dec_fixed_o) |-> (dec_data_o == code_d[DATA_W-1:0]));

   assert_onebit_fix_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && dec_fixed_o) |-> ($countones(dec_data_o ^ code_d[DATA_W-1:0]) <= 1));

endmodule

bind grid_parity_codec gpc_checker #(.ROWS(ROWS), .COLS(COLS), .OUT_REG(OUT_REG)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .enc_data_i  (enc_data_i),
   .enc_code_o  (enc_code_o),
   .dec_code_i  (dec_code_i),
   .dec_data_o  (dec_data_o),
   .dec_fixed_o (dec_fixed_o),
   .dec_fatal_o (dec_fatal_o)
);

// File: tb/grid_parity_codec_tb_top.sv
module grid_parity_codec_tb_top;

   localparam int ROWS    = 8;
   localparam int COLS    = 8;
   localparam bit OUT_REG = 1'b1;
   localparam int DATA_W  = ROWS * COLS;
   localparam int CODE_W  = DATA_W + ROWS + COLS + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DATA_W-1:0] enc_data = '0;
   logic [CODE_W-1:0] enc_code;
   logic [CODE_W-1:0] dec_code = '0;
   logic [DATA_W-1:0] dec_data;
   logic              dec_fixed, dec_fatal;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   grid_parity_codec #(.ROWS(ROWS), .COLS(COLS), .OUT_REG(OUT_REG)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .enc_data_i  (enc_data),
      .enc_code_o  (enc_code),
      .dec_code_i  (dec_code),
      .dec_data_o  (dec_data),
      .dec_fixed_o (dec_fixed),
      .dec_fatal_o (dec_fatal)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [CODE_W-1:0] ref_enc(input logic [DATA_W-1:0] d);
      logic [CODE_W-1:0] w;
      w = '0;
      w[DATA_W-1:0] = d;
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            w[DATA_W + r]        = w[DATA_W + r] ^ d[r*COLS + c];
            w[DATA_W + ROWS + c] = w[DATA_W + ROWS + c] ^ d[r*COLS + c];
            w[CODE_W - 1]        = w[CODE_W - 1] ^ d[r*COLS + c];
         end
      end
      return w;
   endfunction

   function automatic logic [DATA_W-1:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   // Called on a falling edge; results read on the next falling edge
   task automatic apply(input logic [DATA_W-1:0] e, input logic [CODE_W-1:0] d);
      enc_data = e;
      dec_code = d;
      @(negedge clk);
   endtask

   task automatic t_reset();
      enc_data = rnd64();
      dec_code = ~'0;
      @(negedge clk);
      chk(enc_code == '0, "R8 reset enc", 128'(enc_code), 128'(0));
      chk(dec_data == '0 && !dec_fixed && !dec_fatal, "R8 reset dec",
          128'({dec_data, dec_fixed, dec_fatal}), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_encode();
      logic [DATA_W-1:0] pats [6];
      pats[0] = '0;
      pats[1] = ~'0;
      pats[2] = 64'h1;
      pats[3] = 64'h8000_0000_0000_0000;
      pats[4] = 64'h0101_0101_0101_0101;
      pats[5] = 64'h0000_0000_0000_00FF;
      foreach (pats[i]) begin
         apply(pats[i], '0);
         chk(enc_code == ref_enc(pats[i]), "R1/R2 fixed pattern", 128'(enc_code), 128'(ref_enc(pats[i])));
      end
      for (int k = 0; k < 20; k++) begin
         logic [DATA_W-1:0] d;
         d = rnd64();
         apply(d, '0);
         chk(enc_code == ref_enc(d), "R1/R2 random", 128'(enc_code), 128'(ref_enc(d)));
      end
   endtask

   task automatic t_clean();
      for (int k = 0; k < 10; k++) begin
         logic [DATA_W-1:0] d;
         d = (k == 0) ? '0 : rnd64();
         apply('0, ref_enc(d));
         chk(dec_data == d && !dec_fixed && !dec_fatal, "R3 clean",
             128'({dec_data, dec_fixed, dec_fatal}), 128'({d, 2'b00}));
      end
   endtask

   task automatic t_single_data();
      for (int k = 0; k < 3; k++) begin
         logic [DATA_W-1:0] d;
         d = rnd64();
         for (int i = 0; i < DATA_W; i++) begin
            apply('0, ref_enc(d) ^ (CODE_W'(1) << i));
            chk(dec_data == d && dec_fixed && !dec_fatal, "R4 single data",
                128'({dec_data, dec_fixed, dec_fatal}), 128'({d, 2'b10}));
         end
      end
   endtask

   task automatic t_single_check();
      for (int k = 0; k < 3; k++) begin
         logic [DATA_W-1:0] d;
         d = rnd64();
         for (int i = DATA_W; i < CODE_W; i++) begin
            apply('0, ref_enc(d) ^ (CODE_W'(1) << i));
            chk(dec_data == d && dec_fixed && !dec_fatal, "R5 single check",
                128'({dec_data, dec_fixed, dec_fatal}), 128'({d, 2'b10}));
         end
      end
   endtask

   task automatic t_double();
      for (int k = 0; k < 2; k++) begin
         logic [DATA_W-1:0] d;
         d = rnd64();
         for (int i = 0; i < CODE_W; i++) begin
            for (int j = i + 1; j < CODE_W; j++) begin
               logic [CODE_W-1:0] w;
               w = ref_enc(d) ^ (CODE_W'(1) << i) ^ (CODE_W'(1) << j);
               apply('0, w);
               chk(dec_data == w[DATA_W-1:0] && !dec_fixed && dec_fatal, "R6 R7 double",
                   128'({dec_data, dec_fixed, dec_fatal}), 128'({w[DATA_W-1:0], 2'b01}));
            end
         end
      end
   endtask

   task automatic t_odd();
      for (int k = 0; k < 200; k++) begin
         logic [CODE_W-1:0] w, m;
         int n;
         n = (k % 2 == 0) ? 3 : 5;
         m = '0;
         while ($countones(m) < n) m[$urandom_range(CODE_W-1, 0)] = 1'b1;
         w = ref_enc(rnd64()) ^ m;
         apply('0, w);
         chk((dec_fixed || dec_fatal) && !(dec_fixed && dec_fatal), "R9 odd weight",
             128'({dec_fixed, dec_fatal}), 128'(1));
      end
   endtask

   task automatic t_latency();
      logic [DATA_W-1:0] a, b;
      a = rnd64();
      b = rnd64();
      apply('0, ref_enc(a));
      dec_code = ref_enc(b) ^ (CODE_W'(1) << 5);
      #1;
      if (OUT_REG) begin
         chk(dec_data == a && !dec_fixed, "R8 holds before edge",
             128'({dec_data, dec_fixed}), 128'({a, 1'b0}));
         @(posedge clk);
         #1;
      end
      chk(dec_data == b && dec_fixed, "R8 result after edge",
          128'({dec_data, dec_fixed}), 128'({b, 1'b1}));
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_encode();
      t_clean();
      t_single_data();
      t_single_check();
      t_double();
      t_odd();
      t_latency();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule